// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritisation

This block gathers the five interrupt causes of a classic byte-oriented UART and applies the software enable mask. It then presents the most urgent enabled cause as a 4-bit identification code inside an identification byte, together with one interrupt request line. The five causes are:

- receiver line errors,
- received data at or above the trigger level,
- receive character timeout,
- transmit holding register empty,
- modem status change.

The receiver, the transmitter and the modem logic deliver single-cycle event strobes. The receive path also supplies its current fill count. The register decode supplies one-cycle access strobes for the line status, receive buffer, modem status, identification and holding registers. The FIFOs, the baud logic and the shifters live elsewhere.

Each cause is cleared in its own way. The line error flags and their interrupt clear when the line status register is read. The timeout clears when the receive buffer is read. The modem cause clears when the modem status register is read. The transmit-empty cause clears on a holding register write, or on an identification read, but only when it is the code being shown. The received-data cause follows the fill count. After any change the presented code is recomputed from what is still pending and enabled.

Reset is asserted asynchronously and is expected to be released synchronously to `clk` by the chip reset tree.

Top module: `uart_irq_ident`

## Requirements
- R1: Fixed priority, highest first, with these codes in bits 3:0 of the identification byte: line error 0x6, received data 0x4, character timeout 0xC, transmit empty 0x2, modem status 0x0. Code 0x1 means nothing is pending.
- R2: The enable register is written through `ier_wr`/`ier_wdata` and holds these bits: bit 0 gates both received data and timeout, bit 1 gates transmit empty, bit 2 gates line error, bit 3 gates modem status. A masked cause stays pending but is not shown. The code is recomputed after each enable write.
- R3: Strobes on `err_overrun`, `err_parity`, `err_frame` and `err_break` set sticky flags, output on `err_flags` bits 0, 1, 2 and 3 in that order. Any set flag makes the line error cause pending.
- R4: Received data is pending while `rx_count` is at or above the trigger level. With `fifo_en` low the level is 1. With `fifo_en` high, `trig_sel` values 0, 1, 2 and 3 select levels 1, 4, 8 and 14.
- R5: A `tx_empty` strobe makes the transmit-empty cause pending. A `thr_wr` strobe clears it.
- R6: While `iir_rd` is high, `iir_byte` carries 1 in bits 7:6, 0 in bits 5:4 and the code in bits 3:0. The read clears the transmit-empty cause only if code 0x2 is being shown.
- R7: An `lsr_rd` strobe clears all four error flags and with them the line error cause.
- R8: An `rbr_rd` strobe clears the timeout cause. An `msr_rd` strobe clears the modem cause.
- R9: After reset the code is 0x1, `irq` is low and the flags are zero. `irq` is high exactly when the code is not 0x1. A strobe in one cycle changes the code in the cycle after its cause register changes.
- R10: A set strobe that arrives in the same cycle as the access that would clear that cause wins, and the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable register write data |
| fifo_en | input | 1 | FIFO mode selects the trigger table |
| trig_sel | input | 2 | Trigger level select |
| rx_count | input | CNT_W | Receive FIFO fill count |
| err_overrun | input | 1 | Overrun event strobe |
| err_parity | input | 1 | Parity error event strobe |
| err_frame | input | 1 | Framing error event strobe |
| err_break | input | 1 | Break event strobe |
| rx_timeout | input | 1 | Character timeout event strobe |
| tx_empty | input | 1 | Holding buffer became empty strobe |
| modem_chg | input | 1 | Modem status change strobe |
| thr_wr | input | 1 | Holding register write strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| iir_rd | input | 1 | Identification register read strobe |
| iir_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |
| err_flags | output | 4 | Sticky line error flags |

## Verification
The assertions assume that every strobe lasts exactly one cycle and that `rx_count` never exceeds the FIFO depth. They also assume that a clearing access and the matching set strobe coincide only in the case the collision rule covers. The directed stimulus drives each strobe for a single cycle on the falling edge. It keeps `rx_count` between 0 and 14, and it applies set and clear together only in the test written for that collision.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_TXEMPTY = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  // enable register bit positions
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_W     = 4;

  // request vector positions, highest priority at the top
  localparam int RQ_MODEM = 0;
  localparam int RQ_TX    = 1;
  localparam int RQ_TOUT  = 2;
  localparam int RQ_RX    = 3;
  localparam int RQ_LINE  = 4;
  localparam int RQ_W     = 5;

  localparam int ERR_W    = 4;

endpackage

// File: rtl/uart_irq_errflags.sv
module uart_irq_errflags
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] set_i,
  input  logic             clr_i,
  output logic [ERR_W-1:0] flags_o,
  output logic             any_o
);

  logic [ERR_W-1:0] flags_d;
  logic [ERR_W-1:0] flags_q;

  for (genvar gi = 0; gi < ERR_W; gi++) begin : g_flag
    always_comb begin
      flags_d[gi] = flags_q[gi];
      if (clr_i)    flags_d[gi] = 1'b0;
      if (set_i[gi]) flags_d[gi] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flags_q[gi] <= 1'b0;
      else if (clr_i | set_i[gi]) flags_q[gi] <= flags_d[gi];
    end
  end

  assign flags_o = flags_q;
  assign any_o   = |flags_q;

  // R7: a status read with no simultaneous error empties every flag
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (flags_o == '0));

  // R3: an error event is visible as a set flag afterwards
  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> any_o);

endmodule

// File: rtl/uart_irq_latch.sv
module uart_irq_latch #(
  parameter int NUM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] pend_o
);

  logic [NUM-1:0] pend_d;
  logic [NUM-1:0] pend_q;

  for (genvar gi = 0; gi < NUM; gi++) begin : g_src
    always_comb begin
      pend_d[gi] = pend_q[gi];
      if (clr_i[gi]) pend_d[gi] = 1'b0;
      if (set_i[gi]) pend_d[gi] = 1'b1;   // set wins on collision
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pend_q[gi] <= 1'b0;
      else if (set_i[gi] | clr_i[gi]) pend_q[gi] <= pend_d[gi];
    end

    // R8 / R5: an uncontested clear drops the source
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[gi] && !set_i[gi]) |=> !pend_o[gi]);

    // R10: a set always leaves the source pending
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[gi] |=> pend_o[gi]);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/uart_irq_trigger.sv
module uart_irq_trigger #(
  parameter int CNT_W = 5,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             hit_o
);

  localparam logic [CNT_W-1:0] L0 = CNT_W'(LVL0);
  localparam logic [CNT_W-1:0] L1 = CNT_W'(LVL1);
  localparam logic [CNT_W-1:0] L2 = CNT_W'(LVL2);
  localparam logic [CNT_W-1:0] L3 = CNT_W'(LVL3);
  localparam logic [CNT_W-1:0] L_CHAR = CNT_W'(1);

  logic [CNT_W-1:0] level;

  always_comb begin
    if (!fifo_en_i) begin
      level = L_CHAR;
    end else begin
      unique case (sel_i)
        2'd0:    level = L0;
        2'd1:    level = L1;
        2'd2:    level = L2;
        default: level = L3;
      endcase
    end
  end

  assign hit_o = (count_i >= level);

  // R4: an empty receive FIFO never requests service
  p_empty_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i == '0) |-> !hit_o);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [RQ_W-1:0] req_i,
  output irq_id_e         id_o
);

  always_comb begin
    if      (req_i[RQ_LINE])  id_o = ID_LINE;
    else if (req_i[RQ_RX])    id_o = ID_RXDATA;
    else if (req_i[RQ_TOUT])  id_o = ID_TIMEOUT;
    else if (req_i[RQ_TX])    id_o = ID_TXEMPTY;
    else if (req_i[RQ_MODEM]) id_o = ID_MODEM;
    else                      id_o = ID_NONE;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [3:0]       ier_wdata,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             err_overrun,
  input  logic             err_parity,
  input  logic             err_frame,
  input  logic             err_break,
  input  logic             rx_timeout,
  input  logic             tx_empty,
  input  logic             modem_chg,
  input  logic             thr_wr,
  input  logic             lsr_rd,
  input  logic             rbr_rd,
  input  logic             msr_rd,
  input  logic             iir_rd,
  output logic [7:0]       iir_byte,
  output logic             irq,
  output logic [3:0]       err_flags
);

  localparam int LT_TOUT  = 0;
  localparam int LT_TX    = 1;
  localparam int LT_MODEM = 2;
  localparam int LT_N     = 3;

  // enable register
  logic [EN_W-1:0] ier_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ier_q <= '0;
    else if (ier_wr) ier_q <= ier_wdata;
  end

  // line error flags
  logic line_pend;
  uart_irq_errflags u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   ({err_break, err_frame, err_parity, err_overrun}),
    .clr_i   (lsr_rd),
    .flags_o (err_flags),
    .any_o   (line_pend)
  );

  // received data level
  logic rx_hit;
  uart_irq_trigger #(
    .CNT_W (CNT_W), .LVL0 (LVL0), .LVL1 (LVL1), .LVL2 (LVL2), .LVL3 (LVL3)
  ) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en_i (fifo_en),
    .sel_i     (trig_sel),
    .count_i   (rx_count),
    .hit_o     (rx_hit)
  );

  // presented code register
  irq_id_e id_q;
  irq_id_e id_d;

  // sticky event sources
  logic [LT_N-1:0] lt_set;
  logic [LT_N-1:0] lt_clr;
  logic [LT_N-1:0] lt_pend;

  always_comb begin
    lt_set           = '0;
    lt_clr           = '0;
    lt_set[LT_TOUT]  = rx_timeout;
    lt_clr[LT_TOUT]  = rbr_rd;
    lt_set[LT_TX]    = tx_empty;
    lt_clr[LT_TX]    = thr_wr | (iir_rd && (id_q == ID_TXEMPTY));
    lt_set[LT_MODEM] = modem_chg;
    lt_clr[LT_MODEM] = msr_rd;
  end

  uart_irq_latch #(.NUM (LT_N)) u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (lt_set),
    .clr_i  (lt_clr),
    .pend_o (lt_pend)
  );

  // masked request vector
  logic [RQ_W-1:0] req;
  always_comb begin
    req           = '0;
    req[RQ_LINE]  = line_pend        & ier_q[EN_LINE];
    req[RQ_RX]    = rx_hit           & ier_q[EN_RX];
    req[RQ_TOUT]  = lt_pend[LT_TOUT] & ier_q[EN_RX];
    req[RQ_TX]    = lt_pend[LT_TX]   & ier_q[EN_TX];
    req[RQ_MODEM] = lt_pend[LT_MODEM] & ier_q[EN_MODEM];
  end

  uart_irq_prio u_prio (
    .req_i (req),
    .id_o  (id_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= ID_NONE;
    else        id_q <= id_d;
  end

  assign iir_byte = {2'b11, 2'b00, id_q};
  assign irq      = (id_q != ID_NONE);

  // R1: an enabled line error is always shown next
  p_line_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pend && ier_q[EN_LINE]) |=> (iir_byte[3:0] == 4'h6));

  // R2: with every enable clear nothing is shown next
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == '0) |=> !irq);

  // R6: the fixed upper bits of the identification byte
  p_top_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iir_byte[7:4] == 4'hC);

  // R5: an uncontested holding write keeps the transmit code away next
  p_thr_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !tx_empty) |=> ##1 (iir_byte[3:0] != 4'h2));

endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

  localparam int CNT_W = 5;

  logic clk, rst_n;
  logic ier_wr; logic [3:0] ier_wdata;
  logic fifo_en; logic [1:0] trig_sel; logic [CNT_W-1:0] rx_count;
  logic err_overrun, err_parity, err_frame, err_break;
  logic rx_timeout, tx_empty, modem_chg, thr_wr;
  logic lsr_rd, rbr_rd, msr_rd, iir_rd;
  logic [7:0] iir_byte; logic irq; logic [3:0] err_flags;

  int checks = 0;
  int errors = 0;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .fifo_en(fifo_en), .trig_sel(trig_sel), .rx_count(rx_count),
    .err_overrun(err_overrun), .err_parity(err_parity), .err_frame(err_frame),
    .err_break(err_break), .rx_timeout(rx_timeout), .tx_empty(tx_empty),
    .modem_chg(modem_chg), .thr_wr(thr_wr), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd),
    .msr_rd(msr_rd), .iir_rd(iir_rd), .iir_byte(iir_byte), .irq(irq),
    .err_flags(err_flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // checks code and irq together; irq must follow R9
  task automatic chk_code(input string req, input int exp);
    chk(req, "code", int'(iir_byte[3:0]), exp);
    chk("R9", "irq", int'(irq), (exp != 1) ? 1 : 0);
  endtask

  task automatic wr_ier(input logic [3:0] v);
    ier_wr = 1'b1; ier_wdata = v; step(1); ier_wr = 1'b0; step(1);
  endtask

  task automatic read_iir(input string req, input int exp_byte);
    iir_rd = 1'b1; #1;
    chk(req, "iir byte", int'(iir_byte), exp_byte);
    step(1); iir_rd = 1'b0; step(1);
  endtask

  task automatic t_reset();
    chk_code("R9", 1);
    chk("R9", "flags after reset", int'(err_flags), 0);
  endtask

  task automatic t_line_errors();
    err_parity = 1'b1; step(1); err_parity = 1'b0; step(1);
    chk("R3", "parity flag bit1", int'(err_flags), 4'b0010);
    chk_code("R2", 1);                    // masked: not shown
    wr_ier(4'b0100);
    chk_code("R3", 6);
    err_break = 1'b1; step(1); err_break = 1'b0; step(1);
    chk("R3", "break plus parity", int'(err_flags), 4'b1010);
    lsr_rd = 1'b1; step(1); lsr_rd = 1'b0; step(1);
    chk("R7", "flags after status read", int'(err_flags), 0);
    chk_code("R7", 1);
    wr_ier(4'b0000);
  endtask

  task automatic t_trigger();
    wr_ier(4'b0001);
    fifo_en = 1'b0; rx_count = 5'd1; step(2);
    chk_code("R4", 4);
    fifo_en = 1'b1; trig_sel = 2'd2; rx_count = 5'd7; step(2);
    chk_code("R4", 1);
    rx_count = 5'd8; step(2);
    chk_code("R4", 4);
    trig_sel = 2'd3; rx_count = 5'd13; step(2);
    chk_code("R4", 1);
    rx_count = 5'd14; step(2);
    chk_code("R4", 4);
    trig_sel = 2'd1; rx_count = 5'd3; step(2);
    chk_code("R4", 1);
    rx_count = 5'd0; trig_sel = 2'd0; step(2);
    wr_ier(4'b0000);
  endtask

  task automatic t_priority();
    wr_ier(4'b1111);
    modem_chg = 1'b1; step(1); modem_chg = 1'b0; step(1);
    chk_code("R1", 0);
    tx_empty = 1'b1; step(1); tx_empty = 1'b0; step(1);
    chk_code("R1", 2);
    rx_timeout = 1'b1; step(1); rx_timeout = 1'b0; step(1);
    chk_code("R1", 12);
    rx_count = 5'd1; step(2);
    chk_code("R1", 4);
    err_overrun = 1'b1; step(1); err_overrun = 1'b0; step(1);
    chk_code("R1", 6);
    lsr_rd = 1'b1; step(1); lsr_rd = 1'b0; step(1);
    chk_code("R7", 4);
    rx_count = 5'd0; step(2);
    chk_code("R4", 12);
    rbr_rd = 1'b1; step(1); rbr_rd = 1'b0; step(1);
    chk_code("R8", 2);
    read_iir("R6", 8'hC2);
    chk_code("R6", 0);
    msr_rd = 1'b1; step(1); msr_rd = 1'b0; step(1);
    chk_code("R8", 1);
  endtask

  task automatic t_iir_not_shown();
    tx_empty = 1'b1; step(1); tx_empty = 1'b0;
    rx_count = 5'd1; step(2);
    chk_code("R6", 4);
    read_iir("R6", 8'hC4);
    rx_count = 5'd0; step(2);
    chk_code("R6", 2);                    // transmit cause survived
    thr_wr = 1'b1; step(1); thr_wr = 1'b0; step(1);
    chk_code("R5", 1);
  endtask

  task automatic t_collision();
    rx_timeout = 1'b1; rbr_rd = 1'b1; step(1);
    rx_timeout = 1'b0; rbr_rd = 1'b0; step(1);
    chk_code("R10", 12);
    rbr_rd = 1'b1; step(1); rbr_rd = 1'b0; step(1);
    chk_code("R8", 1);
    err_frame = 1'b1; lsr_rd = 1'b1; step(1);
    err_frame = 1'b0; lsr_rd = 1'b0; step(1);
    chk("R10", "frame flag kept", int'(err_flags), 4'b0100);
    lsr_rd = 1'b1; step(1); lsr_rd = 1'b0; step(1);
  endtask

  task automatic t_latency_and_mask();
    wr_ier(4'b1000);
    modem_chg = 1'b1; step(1); modem_chg = 1'b0;
    chk_code("R9", 1);                    // cause registered, code not yet
    step(1);
    chk_code("R9", 0);
    wr_ier(4'b0111);
    chk_code("R2", 1);                    // masked but still pending
    wr_ier(4'b1000);
    chk_code("R2", 0);
    msr_rd = 1'b1; step(1); msr_rd = 1'b0; step(1);
    chk_code("R8", 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ier_wr = 0; ier_wdata = 0; fifo_en = 0; trig_sel = 0;
    rx_count = 0; err_overrun = 0; err_parity = 0; err_frame = 0; err_break = 0;
    rx_timeout = 0; tx_empty = 0; modem_chg = 0; thr_wr = 0;
    lsr_rd = 0; rbr_rd = 0; msr_rd = 0; iir_rd = 0;
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_line_errors();
    t_trigger();
    t_priority();
    t_iir_not_shown();
    t_collision();
    t_latency_and_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule